// File: doc/BRIEF.md
# Board Interrupt Hub with Socket Card-Detect

This block gathers sixteen level-sensitive interrupt lines from board peripherals into one interrupt request for the host processor. Software chooses which lines take part by writing an enable register. Any line that is high while its enable bit is set records a sticky pending bit. The host interrupt is raised whenever an enabled line has a pending bit. Software acknowledges by rewriting the pending register with the bits it wants to keep.

Two of the lines also report card presence for two expansion sockets. Each socket has a status/control word whose card-detect flag is active low and follows its line. Software may change only the five low control bits of a socket word. The block also holds a bank of plain scratch words and a read-only status word.

The bus is a plain 32-bit register port. It is always ready and has no back-pressure. A read returns data in the same cycle the strobe is high. A write takes effect at the next clock edge. Accesses to offsets that map to nothing are reported on a one-cycle error flag.

Top module: `brd_irq_hub`

## Requirements
- R1: After reset, the enable, pending and scratch words read zero, both socket words read 0x420, and `irq_out` and `bus_err` are low.
- R2: A write to offset 0xC0 stores the data ANDed with 0x000FEEFF in the enable register. Bits 8 and 12 can therefore never be enabled, and offset 0xC0 reads back the stored value.
- R3: A write to offset 0xD0 replaces the whole pending register with the data ANDed with 0x000FEEFF. Offset 0xD0 reads it back.
- R4: At every clock edge where line k is high and enable bit k is already set, pending bit k becomes 1. The bit stays set after the line falls. Cycles in which the line was high while disabled leave no trace.
- R5: `irq_out` is high exactly when the pending register ANDed with the enable register is nonzero. It follows the state produced at the previous clock edge.
- R6: When a pending-register write and latching happen at the same edge, the written value wins for that edge.
- R7: Bit 5 of the socket word at 0xE0 is the inverse of line 9 as sampled at the last clock edge. Bit 5 of the socket word at 0xE4 is the inverse of line 13 in the same way.
- R8: A write to either socket word changes only its bits 4:0. Bit 10 (ready) stays 1, and bit 5 and all other upper bits are untouched by the write.
- R9: The words at 0x10, 0x14, 0x40, 0x60, 0x80, 0x84 and 0x88 are independent 32-bit read/write storage.
- R10: Offset 0x90 always reads zero. A write to it has no effect and raises no error.
- R11: A read from an unmapped offset returns zero. A write to an unmapped offset changes nothing. Either access sets `bus_err` high for one cycle after the clock edge that ends the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte offset of the register access |
| bus_wr | input | 1 | Write strobe, acted on at the clock edge |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| bus_err | output | 1 | One-cycle flag for an unmapped access |
| irq_in | input | 16 | Level interrupt lines |
| irq_out | output | 1 | Combined interrupt request to the host |

## Verification
Several rules are checked by assertions on every cycle:
- pending bits set for every enabled high line, and a pending write overriding that;
- the socket card-detect bits tracking their lines one cycle later, with the socket ready bit and upper bits never moving;
- `irq_out` never high without a pending bit;
- `bus_err` appearing only after an unmapped access, and unmapped reads returning zero.

The bench scenarios are needed for the rest:
- the masked field layout seen through readback;
- a line that was high only while disabled leaving no pending bit;
- socket writes limited to the control bits;
- the scratch words not aliasing one another;
- the read-only word ignoring writes.

// File: rtl/brd_irq_pkg.sv
package brd_irq_pkg;
  localparam int AW      = 8;
  localparam int DW      = 32;
  localparam int N_STORE = 7;

  localparam logic [DW-1:0] IRQ_FIELD_MASK = 32'h000F_EEFF;
  localparam logic [DW-1:0] SOCK_RST_VAL   = 32'h0000_0420;
  localparam int            SOCK_CTRL_W    = 5;
  localparam int            SOCK_CD_BIT    = 5;

  localparam logic [AW-1:0] OFF_EN    = 8'hC0;
  localparam logic [AW-1:0] OFF_PEND  = 8'hD0;
  localparam logic [AW-1:0] OFF_SOCK0 = 8'hE0;
  localparam logic [AW-1:0] OFF_SOCK1 = 8'hE4;
  localparam logic [AW-1:0] OFF_STAT  = 8'h90;

  typedef struct packed {
    logic               hit_en;
    logic               hit_pend;
    logic [1:0]         hit_sock;
    logic [N_STORE-1:0] hit_store;
    logic               hit_stat;
  } dec_t;

  function automatic logic [AW-1:0] store_off(input int idx);
    case (idx)
      0:       return 8'h10;
      1:       return 8'h14;
      2:       return 8'h40;
      3:       return 8'h60;
      4:       return 8'h80;
      5:       return 8'h84;
      default: return 8'h88;
    endcase
  endfunction

  function automatic dec_t decode(input logic [AW-1:0] a);
    dec_t d;
    d = '0;
    case (a)
      OFF_EN:    d.hit_en      = 1'b1;
      OFF_PEND:  d.hit_pend    = 1'b1;
      OFF_SOCK0: d.hit_sock[0] = 1'b1;
      OFF_SOCK1: d.hit_sock[1] = 1'b1;
      OFF_STAT:  d.hit_stat    = 1'b1;
      default: begin
        for (int i = 0; i < N_STORE; i++)
          if (a == store_off(i)) d.hit_store[i] = 1'b1;
      end
    endcase
    return d;
  endfunction

  function automatic logic is_mapped(input logic [AW-1:0] a);
    return |decode(a);
  endfunction
endpackage

// File: rtl/brd_irq_pend.sv
module brd_irq_pend #(
  parameter int N_LINES = 16,
  parameter int DW      = 32,
  parameter logic [DW-1:0] FIELD_MASK = 32'h000F_EEFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_wr,
  input  logic          pend_wr,
  input  logic [DW-1:0] wdata,
  input  logic [N_LINES-1:0] lines,
  output logic [DW-1:0] en_q,
  output logic [DW-1:0] pend_q,
  output logic          irq_out
);
  logic [DW-1:0] lines_ext;
  logic [DW-1:0] latch_set;

  assign lines_ext = DW'(lines);
  assign latch_set = lines_ext & en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr) en_q <= wdata & FIELD_MASK;
      // bus write replaces the register and overrides latching at this edge
      if (pend_wr) pend_q <= wdata & FIELD_MASK;
      else         pend_q <= pend_q | latch_set;
    end
  end

  assign irq_out = |(pend_q & en_q);
endmodule

// File: rtl/brd_sock_reg.sv
module brd_sock_reg #(
  parameter int DW     = 32,
  parameter int CTRL_W = 5,
  parameter int CD_BIT = 5,
  parameter logic [DW-1:0] RST_VAL = 32'h0000_0420
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CTRL_W-1:0] wctrl,
  input  logic              cd_line,
  output logic [DW-1:0]     q
);
  logic [DW-1:0] nxt;

  always_comb begin
    nxt = q;
    if (wr) nxt[CTRL_W-1:0] = wctrl;
    nxt[CD_BIT] = ~cd_line;   // card-detect is active low
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= nxt;
  end
endmodule

// File: rtl/brd_store_bank.sv
module brd_store_bank #(
  parameter int N_REGS = 7,
  parameter int DW     = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_REGS-1:0]          wr_sel,
  input  logic [DW-1:0]              wdata,
  output logic [N_REGS-1:0][DW-1:0]  q
);
  for (genvar g = 0; g < N_REGS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)         q[g] <= '0;
      else if (wr_sel[g]) q[g] <= wdata;
    end
  end
endmodule

// File: rtl/brd_irq_hub.sv
module brd_irq_hub
  import brd_irq_pkg::*;
#(
  parameter int N_LINES  = 16,
  parameter int CD0_LINE = 9,
  parameter int CD1_LINE = 13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DW-1:0]      bus_wdata,
  output logic [DW-1:0]      bus_rdata,
  output logic               bus_err,
  input  logic [N_LINES-1:0] irq_in,
  output logic               irq_out
);
  localparam int N_SOCK = 2;
  localparam int CD_LINE [N_SOCK] = '{CD0_LINE, CD1_LINE};

  dec_t dec;
  logic [DW-1:0] en_q, pend_q;
  logic [N_SOCK-1:0][DW-1:0] sock_q;
  logic [N_STORE-1:0][DW-1:0] store_q;
  logic [DW-1:0] sock0_q, sock1_q;
  logic err_q;

  assign dec = decode(bus_addr);

  brd_irq_pend #(.N_LINES(N_LINES), .DW(DW), .FIELD_MASK(IRQ_FIELD_MASK)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .en_wr(bus_wr & dec.hit_en), .pend_wr(bus_wr & dec.hit_pend),
    .wdata(bus_wdata), .lines(irq_in),
    .en_q(en_q), .pend_q(pend_q), .irq_out(irq_out)
  );

  for (genvar s = 0; s < N_SOCK; s++) begin : g_sock
    brd_sock_reg #(.DW(DW), .CTRL_W(SOCK_CTRL_W), .CD_BIT(SOCK_CD_BIT),
                   .RST_VAL(SOCK_RST_VAL)) u_sock (
      .clk(clk), .rst_n(rst_n),
      .wr(bus_wr & dec.hit_sock[s]),
      .wctrl(bus_wdata[SOCK_CTRL_W-1:0]),
      .cd_line(irq_in[CD_LINE[s]]),
      .q(sock_q[s])
    );
  end

  assign sock0_q = sock_q[0];
  assign sock1_q = sock_q[1];

  brd_store_bank #(.N_REGS(N_STORE), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_sel({N_STORE{bus_wr}} & dec.hit_store),
    .wdata(bus_wdata), .q(store_q)
  );

  // status word at the read-only offset has no source and reads zero
  always_comb begin
    bus_rdata = '0;
    if (dec.hit_en)      bus_rdata = en_q;
    if (dec.hit_pend)    bus_rdata = pend_q;
    if (dec.hit_sock[0]) bus_rdata = sock_q[0];
    if (dec.hit_sock[1]) bus_rdata = sock_q[1];
    for (int i = 0; i < N_STORE; i++)
      if (dec.hit_store[i]) bus_rdata = store_q[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= (bus_wr | bus_rd) & ~(|dec);
  end
  assign bus_err = err_q;
endmodule

module brd_irq_hub_chk
  import brd_irq_pkg::*;
#(
  parameter int N_LINES  = 16,
  parameter int CD0_LINE = 9,
  parameter int CD1_LINE = 13
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      bus_addr,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DW-1:0]      bus_wdata,
  input logic [DW-1:0]      bus_rdata,
  input logic               bus_err,
  input logic [N_LINES-1:0] irq_in,
  input logic               irq_out,
  input logic [DW-1:0]      en_q,
  input logic [DW-1:0]      pend_q,
  input logic [DW-1:0]      sock0_q,
  input logic [DW-1:0]      sock1_q
);
  logic pend_wr_c;
  logic [DW-1:0] want_set;
  assign pend_wr_c = bus_wr && (bus_addr == OFF_PEND);
  assign want_set  = DW'(irq_in) & en_q;

  a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_wr_c |=> ((pend_q & $past(want_set)) == $past(want_set)));

  a_r6_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    pend_wr_c |=> (pend_q == ($past(bus_wdata) & IRQ_FIELD_MASK)));

  a_r5_out_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (pend_q != '0));

  a_r7_cd0: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sock0_q[SOCK_CD_BIT] == !$past(irq_in[CD0_LINE])));

  a_r7_cd1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (sock1_q[SOCK_CD_BIT] == !$past(irq_in[CD1_LINE])));

  a_r8_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sock0_q[10] && sock1_q[10] && (sock0_q[DW-1:11] == '0) && (sock1_q[DW-1:11] == '0));

  a_r11_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> $past((bus_wr || bus_rd) && !is_mapped(bus_addr)));

  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !is_mapped(bus_addr)) |-> (bus_rdata == '0));
endmodule

bind brd_irq_hub brd_irq_hub_chk #(.N_LINES(N_LINES), .CD0_LINE(CD0_LINE), .CD1_LINE(CD1_LINE)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_in(irq_in),
  .irq_out(irq_out), .en_q(en_q), .pend_q(pend_q), .sock0_q(sock0_q), .sock1_q(sock1_q)
);

// File: tb/brd_irq_hub_tb.sv
module brd_irq_hub_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err;
  logic [15:0] irq_in = '0;
  logic        irq_out;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;   // 125 MHz

  brd_irq_hub u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .irq_in(irq_in), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick(1);
    bus_wr = 1'b0;
  endtask

  // driver: pushes expected read data, the monitor compares it
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    tick(1);
    bus_rd = 1'b0;
  endtask

  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, bus_rdata, e);
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_errors++; n_checks++;
      $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);
    check("R1 bus_err", {31'b0, bus_err}, 32'h0);
    rd(8'hC0, 32'h0, "R1 enable");
    rd(8'hD0, 32'h0, "R1 pending");
    rd(8'hE0, 32'h420, "R1 socket0");
    rd(8'hE4, 32'h420, "R1 socket1");
    rd(8'h10, 32'h0, "R1 scratch");

    // R2 enable mask
    wr(8'hC0, 32'hFFFF_FFFF);
    rd(8'hC0, 32'h000F_EEFF, "R2 enable masked");
    wr(8'hC0, 32'h0);

    // R3 pending write, R5 output
    wr(8'hD0, 32'hFFFF_FFFF);
    rd(8'hD0, 32'h000F_EEFF, "R3 pending masked");
    check("R5 out low when nothing enabled", {31'b0, irq_out}, 32'h0);
    wr(8'hC0, 32'h0000_0001);
    check("R5 out high pend&en", {31'b0, irq_out}, 32'h1);
    wr(8'hD0, 32'h0);
    check("R5 out low after clear", {31'b0, irq_out}, 32'h0);
    wr(8'hC0, 32'h0);

    // R4 disabled line leaves no trace
    irq_in = 16'h0008;
    tick(3);
    irq_in = 16'h0;
    tick(1);
    wr(8'hC0, 32'h0000_0008);
    rd(8'hD0, 32'h0, "R4 no latch while disabled");
    check("R4 out stays low", {31'b0, irq_out}, 32'h0);
    irq_in = 16'h0008;
    tick(1);
    check("R5 out after latch", {31'b0, irq_out}, 32'h1);
    irq_in = 16'h0;
    tick(2);
    rd(8'hD0, 32'h0000_0008, "R4 sticky pending");
    // lines 8 and 12 can never be enabled
    wr(8'hC0, 32'h0000_FFFF);
    rd(8'hC0, 32'h0000_EEFF, "R2 bits 8 and 12 dropped");
    irq_in = 16'h1100;
    tick(2);
    irq_in = 16'h0;
    rd(8'hD0, 32'h0000_0008, "R4 lines 8 and 12 never pend");

    // R6 write wins over latching at the same edge
    wr(8'hC0, 32'h0000_0001);
    wr(8'hD0, 32'h0);
    irq_in = 16'h0001;
    tick(1);
    check("R4 level latch", {31'b0, irq_out}, 32'h1);
    wr(8'hD0, 32'h0);
    check("R6 write wins", {31'b0, irq_out}, 32'h0);
    tick(1);
    check("R4 relatch next edge", {31'b0, irq_out}, 32'h1);
    irq_in = 16'h0;
    wr(8'hD0, 32'h0);
    wr(8'hC0, 32'h0);

    // R7 card-detect follows lines 9 and 13
    irq_in = 16'h0200;
    tick(1);
    rd(8'hE0, 32'h400, "R7 socket0 card present");
    rd(8'hE4, 32'h420, "R7 socket1 unaffected");
    irq_in = 16'h2000;
    tick(1);
    rd(8'hE4, 32'h400, "R7 socket1 card present");
    rd(8'hE0, 32'h420, "R7 socket0 card gone");
    irq_in = 16'h0;
    tick(1);
    rd(8'hE4, 32'h420, "R7 socket1 card gone");

    // R8 socket writes touch bits 4:0 only
    wr(8'hE0, 32'hFFFF_FFFF);
    rd(8'hE0, 32'h43F, "R8 socket0 control set");
    wr(8'hE4, 32'hFFFF_FFE5);
    rd(8'hE4, 32'h425, "R8 socket1 partial");
    irq_in = 16'h0200;
    wr(8'hE0, 32'hFFFF_FFE0);
    rd(8'hE0, 32'h400, "R8 socket0 clear with card");
    irq_in = 16'h0;

    // R9 scratch words independent
    for (int i = 0; i < 7; i++) begin
      logic [7:0] offs [7];
      offs = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88};
      wr(offs[i], 32'hA5A5_0000 + 32'(i) * 32'h0101_1111);
    end
    for (int i = 0; i < 7; i++) begin
      logic [7:0] offs [7];
      offs = '{8'h10, 8'h14, 8'h40, 8'h60, 8'h80, 8'h84, 8'h88};
      rd(offs[i], 32'hA5A5_0000 + 32'(i) * 32'h0101_1111, "R9 scratch readback");
    end

    // R10 read-only word
    wr(8'h90, 32'hFFFF_FFFF);
    check("R10 no error on write", {31'b0, bus_err}, 32'h0);
    rd(8'h90, 32'h0, "R10 reads zero");

    // R11 unmapped accesses
    rd(8'h20, 32'h0, "R11 unmapped read zero");
    check("R11 err after read", {31'b0, bus_err}, 32'h1);
    tick(1);
    check("R11 err one cycle", {31'b0, bus_err}, 32'h0);
    wr(8'hC4, 32'hFFFF_FFFF);
    check("R11 err after write", {31'b0, bus_err}, 32'h1);
    wr(8'h11, 32'hFFFF_FFFF);
    rd(8'hC0, 32'h0, "R11 enable untouched");
    rd(8'h10, 32'hA5A5_0000, "R11 scratch untouched");
    check("R11 err clear after mapped read", {31'b0, bus_err}, 32'h0);

    tick(2);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule